// File: doc/BRIEF.md
# Flash Chip Erase Sequencer

This block runs a whole-array erase for a flash device that is split into a fixed number of blocks. The command decoder gives it one pulse when the final write-enable rising edge of the chip-erase command sequence arrives. The sequencer then visits the blocks in ascending index order and passes over every block whose protection bit is set. For each remaining block it asks the cell-level engine for three operations in turn. First it programs every cell of the block to zero. Then it erases the block. Then it verifies that the block is erased. The cell-level engine is reached through a request/done/pass handshake.

While the sequencer runs, it drives a busy status flag and ignores every incoming command. If all blocks are protected, it erases nothing and holds busy for a fixed time before it returns to read mode. A verify failure leaves it stuck and busy, with an error flag raised and no report of which block failed. Only the reset command or the hardware reset releases it from that state. The hardware reset also aborts an erase at any point, and the array is then left partly erased.

Top module: `chip_erase_seq`

## Requirements
- R1: While `rst_ni` is low and just after it is released, `busy_o`, `fail_o` and `op_req_o` are all low.
- R2: A `start_i` pulse in the idle state raises `busy_o` from the next clock cycle.
- R3: For each unprotected block, taken in ascending index order, exactly three operations are requested: program to zero (`op_kind_o`=0), then erase (1), then verify (2). Each request carries the block index on `op_blk_o`.
- R4: No operation is requested for a block whose bit in `prot_mask_i` is 1.
- R5: If all bits of `prot_mask_i` are 1, no operation is requested. `busy_o` stays high for exactly `TMO_CYC` cycles and then the sequencer is idle.
- R6: After the last unprotected block verifies with pass, the sequencer returns to idle with `fail_o` low.
- R7: While an erase is running and not failed, `start_i` and `reset_cmd_i` have no effect, and the operation sequence continues unchanged.
- R8: A verify completed with `op_pass_i`=0 puts the sequencer into a failure state. In that state `busy_o` and `fail_o` stay high and `op_req_o` stays low for as long as no reset arrives.
- R9: In the failure state, a `reset_cmd_i` pulse returns the sequencer to idle on the next cycle, with `busy_o` and `fail_o` low.
- R10: Driving `rst_ni` low aborts a running erase at once: `busy_o` and `op_req_o` go low without waiting for a clock edge.
- R11: While `op_req_o` is high and `op_done_i` is low, `op_req_o`, `op_kind_o` and `op_blk_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| start_i | input | 1 | One-cycle pulse when the final write-enable edge of the erase command arrives |
| reset_cmd_i | input | 1 | Reset command pulse from the command decoder |
| prot_mask_i | input | NUM_BLK | Protection bit for each block; 1 means protected |
| op_req_o | output | 1 | Request to the cell-level engine |
| op_kind_o | output | 2 | Requested operation: 0 program to zero, 1 erase, 2 verify |
| op_blk_o | output | BLK_W | Index of the block being operated on |
| op_done_i | input | 1 | One-cycle completion strobe for the current request |
| op_pass_i | input | 1 | Result that comes with `op_done_i`; it is used only for verify |
| busy_o | output | 1 | Hardware status flag: high while an erase is running or stuck |
| fail_o | output | 1 | High in the failure state |

## Verification
The assertions assume three things about the inputs. `prot_mask_i` does not change while `busy_o` is high. `op_done_i` is a single-cycle strobe that is given only while `op_req_o` is high. `op_pass_i` is valid in the same cycle as that strobe. The bench meets these assumptions in the following way. It sets the mask before each start pulse and leaves it alone until the run is over. Its model of the cell-level engine waits a fixed latency after each request. It then raises the done strobe for exactly one cycle, with the pass result chosen for that run. Start and reset-command pulses are injected during runs only on negative clock edges.

// File: rtl/ces_pkg.sv
package ces_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_OP,
    ST_ALLP,
    ST_FAIL
  } ces_state_e;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_VERIFY = 2'd2
  } ces_op_e;
endpackage

// File: rtl/ces_prot_lookup.sv
module ces_prot_lookup #(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input  logic [NUM_BLK-1:0] mask_i,
  input  logic [BLK_W-1:0]   blk_i,
  output logic               prot_o,
  output logic               last_o,
  output logic               all_prot_o
);
  localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLK - 1);

  always_comb begin
    prot_o = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (blk_i == BLK_W'(i)) prot_o = mask_i[i];
    end
  end

  assign last_o     = (blk_i == LAST_IDX);
  assign all_prot_o = &mask_i;
endmodule

// File: rtl/ces_blk_ctr.sv
module ces_blk_ctr #(
  parameter int BLK_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [BLK_W-1:0] blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    blk_o <= '0;
    else if (clr_i) blk_o <= '0;
    else if (inc_i) blk_o <= blk_o + 1'b1;
  end
endmodule

// File: rtl/ces_timer.sv
module ces_timer #(
  parameter int TMO_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic exp_o
);
  localparam int TMR_W = $clog2(TMO_CYC + 1);
  localparam logic [TMR_W-1:0] LIMIT = TMR_W'(TMO_CYC - 1);

  logic [TMR_W-1:0] cnt_q;

  assign exp_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && !exp_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import ces_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int TMO_CYC = 5000,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               reset_cmd_i,
  input  logic [NUM_BLK-1:0] prot_mask_i,
  output logic               op_req_o,
  output logic [1:0]         op_kind_o,
  output logic [BLK_W-1:0]   op_blk_o,
  input  logic               op_done_i,
  input  logic               op_pass_i,
  output logic               busy_o,
  output logic               fail_o
);
  ces_state_e state_q, state_d;
  ces_op_e    op_q, op_d;
  logic       blk_clr, blk_inc, tmr_clr, tmr_en;
  logic       prot, last, all_prot, tmr_exp;
  logic [BLK_W-1:0] blk;

  ces_blk_ctr #(.BLK_W(BLK_W)) u_blk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (blk_clr),
    .inc_i (blk_inc),
    .blk_o (blk)
  );

  ces_prot_lookup #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_lut (
    .mask_i    (prot_mask_i),
    .blk_i     (blk),
    .prot_o    (prot),
    .last_o    (last),
    .all_prot_o(all_prot)
  );

  ces_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .exp_o (tmr_exp)
  );

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    blk_clr = 1'b0;
    blk_inc = 1'b0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          blk_clr = 1'b1;
          tmr_clr = 1'b1;
          state_d = all_prot ? ST_ALLP : ST_SEL;
        end
      end
      ST_SEL: begin
        if (prot) begin
          if (last) state_d = ST_IDLE;
          else      blk_inc = 1'b1;
        end else begin
          state_d = ST_OP;
          op_d    = OP_PROG;
        end
      end
      ST_OP: begin
        if (op_done_i) begin
          unique case (op_q)
            OP_PROG:  op_d = OP_ERASE;
            OP_ERASE: op_d = OP_VERIFY;
            default: begin
              if (!op_pass_i)  state_d = ST_FAIL;
              else if (last)   state_d = ST_IDLE;
              else begin
                blk_inc = 1'b1;
                state_d = ST_SEL;
              end
            end
          endcase
        end
      end
      ST_ALLP: begin
        tmr_en = 1'b1;
        if (tmr_exp) state_d = ST_IDLE;
      end
      ST_FAIL: begin
        // stuck until reset command; block index is not reported
        if (reset_cmd_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign fail_o    = (state_q == ST_FAIL);
  assign op_req_o  = (state_q == ST_OP);
  assign op_kind_o = op_q;
  assign op_blk_o  = blk;
endmodule

// File: rtl/ces_checker.sv
module ces_checker #(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               reset_cmd_i,
  input logic [NUM_BLK-1:0] prot_mask_i,
  input logic               op_req_o,
  input logic [1:0]         op_kind_o,
  input logic [BLK_W-1:0]   op_blk_o,
  input logic               op_done_i,
  input logic               op_pass_i,
  input logic               busy_o,
  input logic               fail_o
);
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o);

  a_r3_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |-> op_kind_o != 2'd3);

  a_r4_no_prot_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |-> !prot_mask_i[op_blk_o]);

  a_r8_verify_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o && op_done_i && op_kind_o == 2'd2 && !op_pass_i |=> fail_o);

  a_r8_fail_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> busy_o && !op_req_o);

  a_r8_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !reset_cmd_i |=> fail_o);

  a_r9_reset_cmd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && reset_cmd_i |=> !busy_o && !fail_o);

  a_r11_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o && !op_done_i |=> op_req_o && $stable(op_kind_o) && $stable(op_blk_o));
endmodule

bind chip_erase_seq ces_checker #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_chk (.*);

// File: tb/tb_chip_erase_seq.sv
module tb_chip_erase_seq;
  localparam int NB  = 4;
  localparam int TMO = 20;
  localparam int BW  = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, reset_cmd_i = 1'b0;
  logic [NB-1:0] prot = '0;
  logic          op_req, op_done = 1'b0, op_pass = 1'b1;
  logic [1:0]    op_kind;
  logic [BW-1:0] op_blk;
  logic          busy, fail;

  int n_tests = 0, n_fail = 0;

  always #5ns clk = ~clk;

  chip_erase_seq #(.NUM_BLK(NB), .TMO_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .reset_cmd_i(reset_cmd_i),
    .prot_mask_i(prot), .op_req_o(op_req), .op_kind_o(op_kind), .op_blk_o(op_blk),
    .op_done_i(op_done), .op_pass_i(op_pass), .busy_o(busy), .fail_o(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nth_unprot(input logic [NB-1:0] m, input int n);
    int c = 0;
    for (int b = 0; b < NB; b++) begin
      if (!m[b]) begin
        if (c == n) return b;
        c++;
      end
    end
    return -1;
  endfunction

  // fail_blk < 0: all verifies pass; inject: pulse start/reset_cmd during the run
  task automatic run_seq(input logic [NB-1:0] m, input int fail_blk, input bit inject);
    int nops = 0, nbusy = 0, lat = 0, exp_ops = 0, bad = 0;
    prot = m;
    @(negedge clk);
    chk(!busy, "R1", busy, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy == 1'b1, "R2", busy, 1);
    for (int cyc = 0; cyc < 2000; cyc++) begin
      op_done = 1'b0;
      if (!busy || fail) break;
      nbusy++;
      if (inject) begin
        start_i     = (cyc % 3 == 0);
        reset_cmd_i = (cyc % 3 == 1);
      end
      if (op_req) begin
        if (lat == 2) begin
          int eb = nth_unprot(m, nops / 3);
          if (int'(op_blk) != eb || int'(op_kind) != nops % 3) bad++;
          op_pass = !(fail_blk == int'(op_blk) && op_kind == 2'd2);
          op_done = 1'b1;
          nops++;
          lat = 0;
        end else lat++;
      end
      @(negedge clk);
    end
    op_done = 1'b0; op_pass = 1'b1; start_i = 1'b0; reset_cmd_i = 1'b0;
    chk(bad == 0, inject ? "R7" : "R3", bad, 0);
    if (fail_blk < 0) begin
      for (int b = 0; b < NB; b++) if (!m[b]) exp_ops += 3;
      chk(nops == exp_ops, "R4", nops, exp_ops);
      chk(!busy && !fail, "R6", {busy, fail}, 0);
      if (&m) chk(nbusy == TMO, "R5", nbusy, TMO);
    end else begin
      for (int b = 0; b < fail_blk; b++) if (!m[b]) exp_ops += 3;
      exp_ops += 3;
      chk(nops == exp_ops, "R8", nops, exp_ops);
      for (int k = 0; k < 10; k++) begin
        chk(busy && fail && !op_req, "R8", {busy, fail, op_req}, 6);
        @(negedge clk);
      end
      reset_cmd_i = 1'b1;
      @(negedge clk);
      reset_cmd_i = 1'b0;
      chk(!busy && !fail, "R9", {busy, fail}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !fail && !op_req, "R1", {busy, fail, op_req}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !fail && !op_req, "R1", {busy, fail, op_req}, 0);

    // every protection pattern
    for (int m = 0; m < (1 << NB); m++) run_seq(NB'(m), -1, 1'b0);
    // commands ignored while running, including the all-protected wait
    run_seq(4'b0000, -1, 1'b1);
    run_seq(4'b1010, -1, 1'b1);
    run_seq(4'b1111, -1, 1'b1);
    // verify failure on each block, with and without protected neighbours
    for (int b = 0; b < NB; b++) run_seq('0, b, 1'b0);
    run_seq(4'b0101, 3, 1'b0);

    // hardware reset mid-erase
    prot = '0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (7) @(negedge clk);
    chk(busy == 1'b1, "R10", busy, 1);
    #2ns rst_ni = 1'b0;
    #1ns chk(!busy && !op_req, "R10", {busy, op_req}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !fail && !op_req, "R1", {busy, fail, op_req}, 0);
    run_seq(4'b0010, -1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500us;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule